// File: doc/BRIEF.md
# LCD Controller SPI Register Access Engine

This block is an SPI master that carries register traffic to a small LCD controller. A host hands it one request at a time: an operation code, an 8-bit register index and 16 bits of write data. The engine turns the request into one or two chip-selected frames on the serial pins and reports completion with a single-cycle done pulse. For read operations, the 16-bit result is presented on `rdata` in the same cycle as that pulse.

Every frame opens with a header byte. The header carries a device-select bit, a bit that chooses between the index register and the data path, and a bit that sets the direction. A register access first points the controller at a register in one frame. It then raises chip select, waits a guard time, and moves the value in a second frame. A status read is a single longer frame in which the first reply byte is meaningless and is thrown away. All transmitted bytes can be complemented for boards that invert the data line. The serial clock rate for this traffic comes from a host setting, but the engine never lets it exceed a ceiling derived from the system clock.

Top module: `lcd_spi_regbus`

## Requirements
- R1: Each frame starts with a header byte laid out MSB first as 0,1,1,1,0,D,S,W. D is `cfg_dev_id`. S=0 addresses the index register and S=1 addresses register data. W=0 is a write and W=1 is a read.
- R2: Operation code 0 (index set) sends one 3-byte frame: the header with S=0 and W=0, then 0x00, then `req_index`.
- R3: Operation code 1 (register write) sends the index-set frame, then a separate 3-byte frame: the header with S=1 and W=0, then `req_wdata[15:8]`, then `req_wdata[7:0]`.
- R4: Operation code 2 (register read) sends the index-set frame, then a 3-byte frame: the header with S=1 and W=0 replaced by W=1, then two 0x00 bytes. `rdata` becomes {second received byte, third received byte} of that frame.
- R5: Operation code 3 (status read) sends one 4-byte frame: the header with S=0 and W=1, then three 0x00 bytes. The second received byte is discarded, and `rdata` becomes {third received byte, fourth received byte}.
- R6: `spi_cs_n` goes high after every frame and stays high for at least two SCLK periods before the next frame begins.
- R7: The SCLK half period is max(`cfg_half_div`, MIN_HALF) system clocks. MIN_HALF = ceil(SYS_CLK_HZ / (2*REG_SCLK_MAX_HZ)), which is 16 at the defaults, so SCLK never runs faster than REG_SCLK_MAX_HZ.
- R8: With `cfg_invert` high, every transmitted bit is complemented: header, filler bytes, index and data. Received bytes are not altered.
- R9: SCLK idles low and stays low while `spi_cs_n` is high. MOSI changes only while SCLK is low, MISO is sampled on the rising SCLK edge, and every byte is sent MSB first.
- R10: `busy` is high from the cycle after a request is accepted until the cycle after `done`. Requests made while busy are ignored. `done` lasts one cycle. `rdata` changes only with the `done` of a read or status read, and writes and index sets leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken when not busy |
| req_op | input | 2 | 0 index set, 1 register write, 2 register read, 3 status read |
| req_index | input | 8 | Register index |
| req_wdata | input | 16 | Register write value |
| cfg_dev_id | input | 1 | Device-select bit placed in every header |
| cfg_invert | input | 1 | Complement all transmitted bytes |
| cfg_half_div | input | DIV_W | Requested SCLK half period in system clocks |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 16 | Result of the last read or status read |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to the controller |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_miso | input | 1 | Serial data from the controller |

## Verification
The bound checker watches the serial protocol on every cycle. It verifies that SCLK stays idle under a released chip select and that MOSI holds steady while SCLK is high. It also checks that no SCLK half period is shorter than the floor, that chip select stays released for at least the guard time, and that `done` and `rdata` update only as R10 allows. Frame contents cannot be judged cycle by cycle, so the bench scenarios cover them: header bit layout, byte order, the two-frame split, the discarded status byte, inversion on transmit only, the clamped or passed-through divider value, and a request made while busy that must produce no frame.

// File: rtl/lcd_spi_pkg.sv
package lcd_spi_pkg;

    typedef enum logic [1:0] {
        OP_INDEX  = 2'd0,
        OP_WRITE  = 2'd1,
        OP_READ   = 2'd2,
        OP_STATUS = 2'd3
    } op_e;

    // frame kinds on the wire
    typedef enum logic [1:0] {
        PH_SEL,   // point at a register
        PH_PUT,   // register value out
        PH_GET,   // register value in
        PH_STAT   // status frame, four bytes
    } phase_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD,
        ST_LEAD,
        ST_SHIFT,
        ST_TAIL,
        ST_GAP,
        ST_FIN
    } state_e;

    typedef struct packed {
        op_e         op;
        logic [7:0]  idx;
        logic [15:0] wdata;
        logic        id;
        logic        inv;
    } req_t;

    localparam logic [4:0] HDR_PREFIX = 5'b01110;

    function automatic logic [7:0] hdr_byte(input logic id, input logic rs, input logic rw);
        return {HDR_PREFIX, id, rs, rw};
    endfunction

    function automatic logic [1:0] last_byte_num(input phase_e ph);
        return (ph == PH_STAT) ? 2'd3 : 2'd2;
    endfunction

    function automatic logic [7:0] frame_byte(
        input phase_e      ph,
        input logic [1:0]  num,
        input logic        id,
        input logic [7:0]  idx,
        input logic [15:0] wdata
    );
        logic [7:0] b;
        b = 8'h00;
        case (ph)
            PH_SEL:  b = (num == 2'd0) ? hdr_byte(id, 1'b0, 1'b0) :
                         (num == 2'd2) ? idx : 8'h00;
            PH_PUT:  b = (num == 2'd0) ? hdr_byte(id, 1'b1, 1'b0) :
                         (num == 2'd1) ? wdata[15:8] : wdata[7:0];
            PH_GET:  b = (num == 2'd0) ? hdr_byte(id, 1'b1, 1'b1) : 8'h00;
            PH_STAT: b = (num == 2'd0) ? hdr_byte(id, 1'b0, 1'b1) : 8'h00;
            default: b = 8'h00;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/lcd_spi_halftick.sv
module lcd_spi_halftick #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [DIV_W-1:0] half,
    output logic             tick
);

    logic [DIV_W-1:0] cnt;

    assign tick = en && (cnt == (half - DIV_W'(1)));

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + DIV_W'(1);
        end
    end

endmodule

// File: rtl/lcd_spi_shifter.sv
module lcd_spi_shifter (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       active,
    input  logic       load,
    input  logic [7:0] load_byte,
    input  logic       miso,
    output logic       sclk,
    output logic       mosi,
    output logic       byte_end,
    output logic [7:0] rx_byte
);

    logic [7:0] tx_q;
    logic [7:0] rx_q;
    logic [2:0] bit_q;

    assign mosi     = tx_q[7];
    assign rx_byte  = rx_q;
    assign byte_end = active && tick && sclk && (bit_q == 3'd7);

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_q  <= '0;
            rx_q  <= '0;
            bit_q <= '0;
            sclk  <= 1'b0;
        end else if (load) begin
            // only ever at a falling edge or with SCLK already low
            tx_q  <= load_byte;
            bit_q <= '0;
            sclk  <= 1'b0;
        end else if (active && tick) begin
            if (!sclk) begin
                sclk <= 1'b1;
                rx_q <= {rx_q[6:0], miso};
            end else begin
                sclk  <= 1'b0;
                tx_q  <= {tx_q[6:0], 1'b0};
                bit_q <= bit_q + 3'd1;
            end
        end
    end

endmodule

// File: rtl/lcd_spi_sequencer.sv
module lcd_spi_sequencer
    import lcd_spi_pkg::*;
#(
    parameter int DIV_W      = 8,
    parameter int MIN_HALF   = 16,
    parameter int GAP_HALVES = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic [1:0]       req_op,
    input  logic [7:0]       req_index,
    input  logic [15:0]      req_wdata,
    input  logic             cfg_dev_id,
    input  logic             cfg_invert,
    input  logic [DIV_W-1:0] cfg_half_div,
    input  logic             tick,
    input  logic             byte_end,
    input  logic [7:0]       rx_byte,
    output logic             clk_en,
    output logic [DIV_W-1:0] half,
    output logic             shift_active,
    output logic             load,
    output logic [7:0]       load_byte,
    output logic             cs_n,
    output logic             busy,
    output logic             done,
    output logic [15:0]      rdata
);

    localparam int GW = $clog2(GAP_HALVES + 1);

    state_e           st;
    req_t             cur;
    phase_e           ph;
    logic [1:0]       bnum;
    logic [GW-1:0]    gcnt;
    logic [15:0]      hold;
    logic [15:0]      rdata_q;
    logic [DIV_W-1:0] half_q;

    logic [1:0] last_num;
    logic       more;
    logic       rx_phase;
    logic       two_phase;
    logic [1:0] sel_num;
    logic [7:0] raw_byte;

    assign last_num  = last_byte_num(ph);
    assign more      = (bnum != last_num);
    assign rx_phase  = (ph == PH_GET) || (ph == PH_STAT);
    assign two_phase = (cur.op == OP_WRITE) || (cur.op == OP_READ);
    assign sel_num   = (st == ST_LOAD) ? 2'd0 : (bnum + 2'd1);
    assign raw_byte  = frame_byte(ph, sel_num, cur.id, cur.idx, cur.wdata);

    assign load         = (st == ST_LOAD) || ((st == ST_SHIFT) && byte_end && more);
    assign load_byte    = cur.inv ? ~raw_byte : raw_byte;
    assign shift_active = (st == ST_SHIFT);
    assign clk_en       = (st inside {ST_LEAD, ST_SHIFT, ST_TAIL, ST_GAP});
    assign cs_n         = !(st inside {ST_LEAD, ST_SHIFT, ST_TAIL});
    assign busy         = (st != ST_IDLE);
    assign done         = (st == ST_FIN);
    assign rdata        = rdata_q;
    assign half         = half_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_IDLE;
            cur     <= '0;
            ph      <= PH_SEL;
            bnum    <= '0;
            gcnt    <= '0;
            hold    <= '0;
            rdata_q <= '0;
            half_q  <= DIV_W'(MIN_HALF);
        end else begin
            case (st)
                ST_IDLE: begin
                    if (req_valid) begin
                        cur.op    <= op_e'(req_op);
                        cur.idx   <= req_index;
                        cur.wdata <= req_wdata;
                        cur.id    <= cfg_dev_id;
                        cur.inv   <= cfg_invert;
                        half_q    <= (cfg_half_div < DIV_W'(MIN_HALF)) ?
                                     DIV_W'(MIN_HALF) : cfg_half_div;
                        ph        <= (op_e'(req_op) == OP_STATUS) ? PH_STAT : PH_SEL;
                        bnum      <= '0;
                        st        <= ST_LOAD;
                    end
                end
                ST_LOAD: begin
                    bnum <= '0;
                    st   <= ST_LEAD;
                end
                ST_LEAD: begin
                    if (tick) st <= ST_SHIFT;
                end
                ST_SHIFT: begin
                    if (byte_end) begin
                        if (rx_phase && (bnum == last_num - 2'd1)) hold[15:8] <= rx_byte;
                        if (rx_phase && (bnum == last_num))        hold[7:0]  <= rx_byte;
                        if (more) begin
                            bnum <= bnum + 2'd1;
                        end else begin
                            st <= ST_TAIL;
                        end
                    end
                end
                ST_TAIL: begin
                    if (tick) begin
                        gcnt <= '0;
                        st   <= ST_GAP;
                    end
                end
                ST_GAP: begin
                    if (tick) begin
                        if (gcnt == GW'(GAP_HALVES - 1)) begin
                            if ((ph == PH_SEL) && two_phase) begin
                                ph <= (cur.op == OP_WRITE) ? PH_PUT : PH_GET;
                                st <= ST_LOAD;
                            end else begin
                                if (rx_phase) rdata_q <= hold;
                                st <= ST_FIN;
                            end
                        end else begin
                            gcnt <= gcnt + GW'(1);
                        end
                    end
                end
                ST_FIN: begin
                    st <= ST_IDLE;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/lcd_spi_regbus.sv
module lcd_spi_regbus #(
    parameter int SYS_CLK_HZ      = 125_000_000,
    parameter int REG_SCLK_MAX_HZ = 4_000_000,
    parameter int DIV_W           = 8,
    parameter int GAP_HALVES      = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic [1:0]       req_op,
    input  logic [7:0]       req_index,
    input  logic [15:0]      req_wdata,
    input  logic             cfg_dev_id,
    input  logic             cfg_invert,
    input  logic [DIV_W-1:0] cfg_half_div,
    output logic             busy,
    output logic             done,
    output logic [15:0]      rdata,
    output logic             spi_sclk,
    output logic             spi_mosi,
    output logic             spi_cs_n,
    input  logic             spi_miso
);

    localparam int MIN_HALF = (SYS_CLK_HZ + 2 * REG_SCLK_MAX_HZ - 1) / (2 * REG_SCLK_MAX_HZ);

    logic             tick;
    logic             clk_en;
    logic [DIV_W-1:0] half;
    logic             shift_active;
    logic             load;
    logic [7:0]       load_byte;
    logic             byte_end;
    logic [7:0]       rx_byte;

    lcd_spi_halftick #(.DIV_W(DIV_W)) u_halftick (
        .clk  (clk),
        .rst  (rst),
        .en   (clk_en),
        .half (half),
        .tick (tick)
    );

    lcd_spi_shifter u_shifter (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .active    (shift_active),
        .load      (load),
        .load_byte (load_byte),
        .miso      (spi_miso),
        .sclk      (spi_sclk),
        .mosi      (spi_mosi),
        .byte_end  (byte_end),
        .rx_byte   (rx_byte)
    );

    lcd_spi_sequencer #(
        .DIV_W      (DIV_W),
        .MIN_HALF   (MIN_HALF),
        .GAP_HALVES (GAP_HALVES)
    ) u_sequencer (
        .clk          (clk),
        .rst          (rst),
        .req_valid    (req_valid),
        .req_op       (req_op),
        .req_index    (req_index),
        .req_wdata    (req_wdata),
        .cfg_dev_id   (cfg_dev_id),
        .cfg_invert   (cfg_invert),
        .cfg_half_div (cfg_half_div),
        .tick         (tick),
        .byte_end     (byte_end),
        .rx_byte      (rx_byte),
        .clk_en       (clk_en),
        .half         (half),
        .shift_active (shift_active),
        .load         (load),
        .load_byte    (load_byte),
        .cs_n         (spi_cs_n),
        .busy         (busy),
        .done         (done),
        .rdata        (rdata)
    );

endmodule

// File: rtl/lcd_spi_regbus_chk.sv
module lcd_spi_regbus_chk #(
    parameter int MIN_HALF   = 16,
    parameter int GAP_HALVES = 4
) (
    input logic        clk,
    input logic        rst,
    input logic        busy,
    input logic        done,
    input logic [15:0] rdata,
    input logic        spi_sclk,
    input logic        spi_mosi,
    input logic        spi_cs_n
);

    logic [15:0] sclk_run;
    logic [15:0] csh_run;
    logic        sclk_prev;
    logic        cs_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_run  <= '1;
            csh_run   <= '1;
            sclk_prev <= 1'b0;
            cs_prev   <= 1'b1;
        end else begin
            sclk_prev <= spi_sclk;
            cs_prev   <= spi_cs_n;
            if (spi_sclk != sclk_prev)  sclk_run <= 16'd1;
            else if (sclk_run != '1)    sclk_run <= sclk_run + 16'd1;
            if (!spi_cs_n)              csh_run  <= '0;
            else if (csh_run != '1)     csh_run  <= csh_run + 16'd1;
        end
    end

    // R9: clock parked low whenever chip select is released
    p_sclk_idle_r9: assert property (@(posedge clk) disable iff (rst)
        spi_cs_n |-> !spi_sclk);

    // R9: data line steady through the high half of SCLK
    p_mosi_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (!spi_cs_n && spi_sclk && $past(spi_sclk)) |-> $stable(spi_mosi));

    // R7: no SCLK half period shorter than the floor
    p_half_floor_r7: assert property (@(posedge clk) disable iff (rst)
        (spi_sclk != sclk_prev) |-> (sclk_run >= 16'(MIN_HALF)));

    // R6: chip select released for the guard time before each frame
    p_cs_gap_r6: assert property (@(posedge clk) disable iff (rst)
        (!spi_cs_n && cs_prev) |-> (csh_run >= 16'(GAP_HALVES * MIN_HALF)));

    // R10: done is a single-cycle pulse
    p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R10: engine is free right after done
    p_done_free_r10: assert property (@(posedge clk) disable iff (rst)
        done |=> !busy);

    // R10: result register moves only with done
    p_rdata_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !$stable(rdata) |-> done);

    // R10: frames only inside a busy transaction
    p_cs_busy_r10: assert property (@(posedge clk) disable iff (rst)
        !spi_cs_n |-> busy);

endmodule

bind lcd_spi_regbus lcd_spi_regbus_chk #(
    .MIN_HALF   (MIN_HALF),
    .GAP_HALVES (GAP_HALVES)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .busy     (busy),
    .done     (done),
    .rdata    (rdata),
    .spi_sclk (spi_sclk),
    .spi_mosi (spi_mosi),
    .spi_cs_n (spi_cs_n)
);

// File: tb/lcd_spi_regbus_tb.sv
`timescale 1ns/1ps
module lcd_spi_regbus_tb;

    localparam int MIN_H = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [1:0]  req_op = 2'd0;
    logic [7:0]  req_index = 8'd0;
    logic [15:0] req_wdata = 16'd0;
    logic        cfg_dev_id = 1'b1;
    logic        cfg_invert = 1'b0;
    logic [7:0]  cfg_half_div = 8'd0;
    logic        busy, done;
    logic [15:0] rdata;
    logic        spi_sclk, spi_mosi, spi_cs_n;
    logic        spi_miso = 1'b0;

    always #4 clk = ~clk;

    lcd_spi_regbus u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
        .req_index(req_index), .req_wdata(req_wdata), .cfg_dev_id(cfg_dev_id),
        .cfg_invert(cfg_invert), .cfg_half_div(cfg_half_div), .busy(busy),
        .done(done), .rdata(rdata), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
        .spi_cs_n(spi_cs_n), .spi_miso(spi_miso)
    );

    // scoreboard FIFOs: written by the driver, drained by the monitors
    logic [31:0] ex_bits [64];
    int          ex_len  [64];
    int          ex_half [64];
    bit          ex_gap  [64];
    string       ex_tag  [64];
    int          fr_wp = 0;
    logic [15:0] ex_rd   [64];
    string       rd_tag  [64];
    int          rd_wp = 0;

    logic [31:0] resp = 32'h0;

    int n_chk = 0, n_fail = 0;        // driver
    int f_chk = 0, f_fail = 0, fr_rp = 0;   // frame monitor
    int r_chk = 0, r_fail = 0, rd_rp = 0;   // result monitor
    int wd_fail = 0;

    function automatic logic [7:0] hb(input logic id, input logic rs, input logic rw);
        return {5'b01110, id, rs, rw};
    endfunction

    function automatic logic [7:0] tx(input logic inv, input logic [7:0] b);
        return inv ? ~b : b;
    endfunction

    task automatic push_frame(input logic [31:0] bits, input int len, input int half,
                              input bit gap, input string tag);
        ex_bits[fr_wp] = bits; ex_len[fr_wp] = len; ex_half[fr_wp] = half;
        ex_gap[fr_wp] = gap; ex_tag[fr_wp] = tag;
        fr_wp++;
    endtask

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // SPI target model plus frame monitor, one process for every pin event
    logic [31:0] sh = 32'h0, cap = 32'h0;
    int          nbits = 0;
    bit          in_frame = 1'b0;
    time         t0 = 0, t1 = 0, t_csrise = 0, gap_t = 0;

    always @(posedge spi_cs_n or negedge spi_cs_n or posedge spi_sclk or negedge spi_sclk) begin
        if (spi_cs_n === 1'b1) begin
            if (in_frame) begin
                in_frame = 1'b0;
                t_csrise = $time;
                f_chk++;
                if (fr_rp >= fr_wp) begin
                    f_fail++;
                    $display("FAIL R10 unexpected frame actual=%0h expected=none", cap);
                end else begin
                    if (nbits != ex_len[fr_rp] * 8 || cap != ex_bits[fr_rp]) begin
                        f_fail++;
                        $display("FAIL %s frame actual=%0h/%0d bits expected=%0h/%0d bits",
                                 ex_tag[fr_rp], cap, nbits, ex_bits[fr_rp], ex_len[fr_rp] * 8);
                    end
                    f_chk++;
                    if ((t1 - t0) != time'(16 * ex_half[fr_rp])) begin
                        f_fail++;
                        $display("FAIL R7 sclk period actual=%0t expected=%0d ns",
                                 t1 - t0, 16 * ex_half[fr_rp]);
                    end
                    if (ex_gap[fr_rp]) begin
                        f_chk++;
                        if (gap_t < time'(32 * ex_half[fr_rp])) begin
                            f_fail++;
                            $display("FAIL R6 cs gap actual=%0t expected>=%0d ns",
                                     gap_t, 32 * ex_half[fr_rp]);
                        end
                    end
                    fr_rp++;
                end
            end
        end else if (spi_cs_n === 1'b0 && !in_frame) begin
            in_frame = 1'b1;
            gap_t    = $time - t_csrise;
            sh       = resp;
            spi_miso = sh[31];
            cap      = 32'h0;
            nbits    = 0;
        end else if (in_frame && spi_sclk === 1'b1) begin
            cap = {cap[30:0], spi_mosi};
            if (nbits == 0) t0 = $time;
            if (nbits == 1) t1 = $time;
            nbits++;
        end else if (in_frame) begin
            sh       = {sh[30:0], 1'b0};
            spi_miso = sh[31];
        end
    end

    // result monitor
    always @(negedge clk) begin
        if (!rst && done) begin
            r_chk++;
            if (rd_rp >= rd_wp) begin
                r_fail++;
                $display("FAIL R10 unexpected done actual=%0h expected=none", rdata);
            end else begin
                if (rdata !== ex_rd[rd_rp]) begin
                    r_fail++;
                    $display("FAIL %s rdata actual=%0h expected=%0h", rd_tag[rd_rp], rdata, ex_rd[rd_rp]);
                end
                rd_rp++;
            end
        end
    end

    logic [15:0] model_rd = 16'h0;

    task automatic run_txn(input logic [1:0] op, input logic [7:0] idx, input logic [15:0] wd,
                           input logic id, input logic inv, input logic [7:0] div,
                           input logic [31:0] rsp, input bit poke, input string tag);
        int half;
        int waited;
        half = (div < 8'(MIN_H)) ? MIN_H : int'(div);
        if (op == 2'd3) begin
            push_frame({tx(inv, hb(id, 1'b0, 1'b1)), tx(inv, 8'h00), tx(inv, 8'h00), tx(inv, 8'h00)},
                       4, half, 1'b0, tag);
            model_rd = rsp[15:0];
        end else begin
            push_frame({8'h00, tx(inv, hb(id, 1'b0, 1'b0)), tx(inv, 8'h00), tx(inv, idx)},
                       3, half, 1'b0, tag);
            if (op == 2'd1)
                push_frame({8'h00, tx(inv, hb(id, 1'b1, 1'b0)), tx(inv, wd[15:8]), tx(inv, wd[7:0])},
                           3, half, 1'b1, tag);
            if (op == 2'd2) begin
                push_frame({8'h00, tx(inv, hb(id, 1'b1, 1'b1)), tx(inv, 8'h00), tx(inv, 8'h00)},
                           3, half, 1'b1, tag);
                model_rd = rsp[23:8];
            end
        end
        ex_rd[rd_wp] = model_rd; rd_tag[rd_wp] = tag; rd_wp++;
        resp = rsp;
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_index = idx; req_wdata = wd;
        cfg_dev_id = id; cfg_invert = inv; cfg_half_div = div;
        @(negedge clk);
        req_valid = 1'b0;
        chk(busy === 1'b1, "R10 busy after accept", 32'(busy), 32'd1);
        if (poke) begin
            repeat (50) @(negedge clk);
            req_valid = 1'b1; req_op = 2'd3; req_index = 8'hFF; cfg_half_div = 8'd1;
            @(negedge clk);
            req_valid = 1'b0;
        end
        waited = 0;
        while (done !== 1'b1 && waited < 20000) begin
            @(negedge clk);
            waited++;
        end
        chk(done === 1'b1, "R10 done timeout", 32'(done), 32'd1);
        @(negedge clk);
        chk(busy === 1'b0 && spi_cs_n === 1'b1, "R10 idle after done",
            {30'd0, busy, spi_cs_n}, 32'd1);
        if (poke) begin
            repeat (600) @(negedge clk);
            chk(busy === 1'b0 && spi_cs_n === 1'b1, "R10 request while busy ignored",
                {30'd0, busy, spi_cs_n}, 32'd1);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==",
                 n_chk + f_chk + r_chk + wd_fail, n_fail + f_fail + r_fail + wd_fail);
    endtask

    initial begin
        #(8ns * 150000);
        wd_fail = 1;
        $display("FAIL watchdog actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(busy === 1'b0 && done === 1'b0 && spi_cs_n === 1'b1 && spi_sclk === 1'b0,
            "R9 R10 reset state", {28'd0, busy, done, spi_cs_n, spi_sclk}, 32'h2);
        rst = 1'b0;
        @(negedge clk);
        chk(rdata === 16'h0, "R10 reset rdata", 32'(rdata), 32'h0);
        // R2 R1 R7: index set, divider clamped to the floor
        run_txn(2'd0, 8'h22, 16'h0000, 1'b1, 1'b0, 8'd0, 32'h0, 1'b0, "R2");
        // R3: register write, two frames
        run_txn(2'd1, 8'h10, 16'h4240, 1'b1, 1'b0, 8'd0, 32'h0, 1'b0, "R3");
        // R4: register read, result from received bytes two and three
        run_txn(2'd2, 8'h00, 16'h0000, 1'b1, 1'b0, 8'd0, 32'h5A922200, 1'b0, "R4");
        // R5: status read, second received byte dropped
        run_txn(2'd3, 8'h00, 16'h0000, 1'b1, 1'b0, 8'd0, 32'h11EE0357, 1'b0, "R5");
        // R8 R1 R7: inverted write with device bit 0, slower divider; rdata kept (R10)
        run_txn(2'd1, 8'h56, 16'h080F, 1'b0, 1'b1, 8'd20, 32'hFFFFFFFF, 1'b0, "R8");
        // R8: inverted read, received bytes not complemented
        run_txn(2'd2, 8'h31, 16'h0000, 1'b0, 1'b1, 8'd0, 32'h00ABCD00, 1'b0, "R8");
        // R10 R7: status read with a request poked in while busy
        run_txn(2'd3, 8'h00, 16'h0000, 1'b0, 1'b0, 8'd5, 32'hFFFF1234, 1'b1, "R10");
        // R2 R7: index set, divider just above the floor
        run_txn(2'd0, 8'hA5, 16'h0000, 1'b1, 1'b0, 8'd17, 32'h0, 1'b0, "R2");
        repeat (200) @(negedge clk);
        chk(fr_rp == fr_wp, "R10 frame count", 32'(fr_rp), 32'(fr_wp));
        chk(rd_rp == rd_wp, "R10 done count", 32'(rd_rp), 32'(rd_wp));
        summary();
        $finish;
    end

endmodule